// File: doc/BRIEF.md
# Four-Frame Grayscale Segment Modulator

This block decides, for a group of display pixels, whether each segment line is driven during the current slice of a line period. Every pixel carries a 2-bit gray code. The block holds eight programmable 16-bit pattern words. Four words serve the normal display mode and four serve the power-save mode. The pixel code selects a word within the active set.

Each pattern word is split into four 4-bit pulse-width fields, one for each frame of a repeating four-frame cycle. An internal frame counter steps once per frame tick and picks the field. A 4-bit line-phase input counts the 15 sub-slots of a line. A segment is on while the phase is below the selected width. This gives a gray level that combines pulse-width and frame-rate modulation.

Top module: `gray_frame_mod`

## Requirements
- R1: After reset, all eight pattern words are zero and the frame counter is 0, so every segment output is off.
- R2: The 2-bit frame counter advances by one on each cycle with `frame_tick` high and wraps from 3 to 0. It holds its value otherwise.
- R3: A write with `wr_en` high loads `wr_data` into one byte of one pattern word. `wr_addr[3]` selects the set (0 normal, 1 power-save), `wr_addr[2:1]` selects the pixel code, and `wr_addr[0]` selects the byte (0 for bits 7:0, 1 for bits 15:8). No other byte changes.
- R4: For frame counter value f, the pulse width k of a pixel is bits [4f+3:4f] of the word picked by its code. The segment is on exactly when `line_phase` < k. So k=0 is never on and k=15 is on for phases 0 to 14.
- R5: `ps_mode` high makes the power-save set active, and low makes the normal set active. The switch takes effect in the same cycle.
- R6: With `disp_on` low, every segment output is off whatever the pixel data and patterns hold.
- R7: A `line_phase` of 15 gives an off output for every pixel and every width.
- R8: Each pixel slot s uses `pix[2s+1:2s]` and drives `seg_on[s]` independently of the other slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Pattern byte write strobe |
| wr_addr | input | 4 | Set, pixel code and byte select |
| wr_data | input | 8 | Pattern byte |
| ps_mode | input | 1 | 1 selects the power-save pattern set |
| disp_on | input | 1 | 0 forces all segments off |
| frame_tick | input | 1 | Advances the frame counter |
| line_phase | input | 4 | Sub-slot index within the line, 0 to 14 |
| pix | input | 2*NSLOT | Packed 2-bit pixel codes, slot 0 in the low bits |
| seg_on | output | NSLOT | Segment on decision per slot |

## Verification
The bench builds the block with NSLOT=3. This puts three codes side by side, so slots can be checked against each other for crosstalk, and it avoids the power-of-two default. Random pattern words and pixel codes are run through every frame value, both sets and all sixteen phase values. Directed cases pin widths 0 and 15, phase 15, the display-off override and the frame wrap.

// File: rtl/gray_frame_mod.sv
module gray_frame_mod #(
  parameter int NSLOT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [3:0]         wr_addr,
  input  logic [7:0]         wr_data,
  input  logic               ps_mode,
  input  logic               disp_on,
  input  logic               frame_tick,
  input  logic [3:0]         line_phase,
  input  logic [2*NSLOT-1:0] pix,
  output logic [NSLOT-1:0]   seg_on
);
  localparam int NWORD = 8;

  logic [NWORD-1:0][15:0] pat_q;
  logic [1:0]             frame_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pat_q <= '0;
    end else if (wr_en) begin
      if (wr_addr[0]) pat_q[wr_addr[3:1]][15:8] <= wr_data;
      else            pat_q[wr_addr[3:1]][7:0]  <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          frame_q <= 2'd0;
    else if (frame_tick) frame_q <= frame_q + 2'd1;
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic [1:0]  code;
    logic [15:0] word;
    logic [3:0]  width;
    assign code  = pix[2*s +: 2];
    assign word  = pat_q[{ps_mode, code}];
    assign width = word[4*frame_q +: 4];
    assign seg_on[s] = disp_on && (line_phase < width);
  end

  // R2
  a_r2_frame_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && frame_q == 2'd3) |=> frame_q == 2'd0);
  a_r2_frame_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_tick |=> $stable(frame_q));
  // R3
  a_r3_no_write_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(pat_q));
  // R6
  a_r6_dark_off: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_on |-> seg_on == '0);
  // R7
  a_r7_phase15_off: assert property (@(posedge clk) disable iff (!rst_n)
    line_phase == 4'd15 |-> seg_on == '0);
  // R1
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (pat_q == '0 && frame_q == 2'd0));
endmodule

// File: tb/gray_frame_mod_tb_top.sv
module gray_frame_mod_tb_top;
  localparam int NS = 3;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic ps_mode = 1'b0, disp_on = 1'b1, frame_tick = 1'b0;
  logic [3:0] line_phase = '0;
  logic [2*NS-1:0] pix = '0;
  logic [NS-1:0] seg_on;

  int checks = 0, fails = 0;
  logic [15:0] m_pat [8];
  int m_frame = 0;

  always #4 clk = ~clk;

  gray_frame_mod #(.NSLOT(NS)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ps_mode(ps_mode), .disp_on(disp_on), .frame_tick(frame_tick),
    .line_phase(line_phase), .pix(pix), .seg_on(seg_on));

  function automatic logic [NS-1:0] expect_seg();
    logic [NS-1:0] r;
    for (int s = 0; s < NS; s++) begin
      logic [15:0] w;
      int k;
      w = m_pat[{ps_mode, pix[2*s +: 2]}];
      k = (w >> (4*m_frame)) & 15;
      r[s] = disp_on && (int'(line_phase) < k);
    end
    return r;
  endfunction

  task automatic check(string req);
    logic [NS-1:0] e;
    #1;
    e = expect_seg();
    checks++;
    if (seg_on !== e) begin
      fails++;
      $display("FAIL %s: seg_on=%b expected=%b", req, seg_on, e);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
    if (a[0]) m_pat[a[3:1]][15:8] = d; else m_pat[a[3:1]][7:0] = d;
  endtask

  task automatic tick();
    @(negedge clk); frame_tick = 1'b1;
    @(negedge clk); frame_tick = 1'b0;
    m_frame = (m_frame + 1) % 4;
  endtask

  task automatic set_word(input int idx, input logic [15:0] w);
    wr(4'(idx*2), w[7:0]);
    wr(4'(idx*2+1), w[15:8]);
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: run hung, actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 8; i++) m_pat[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, all off even at phase 0 with any code
    pix = 6'b111001; line_phase = 4'd0;
    @(negedge clk); check("R1");
    ps_mode = 1'b1; check("R1");
    ps_mode = 1'b0;

    // R3/R4: per-frame widths, low byte frames 0..1, high byte 2..3
    set_word(3, 16'hF0_5A);   // normal code 3: f0=A f1=5 f2=0 f3=F
    set_word(5, 16'h1_2_3_4); // power-save code 1
    pix = {3{2'b11}};
    for (int f = 0; f < 4; f++) begin
      for (int p = 0; p < 16; p++) begin
        @(negedge clk); line_phase = 4'(p); check("R4");
      end
      tick();
    end
    // R2: wrap back to frame 0 verified by width A boundary
    @(negedge clk); line_phase = 4'd9; check("R2");
    line_phase = 4'd10; check("R2");

    // R3: writing the high byte leaves low byte intact
    wr(4'd7, 8'h00);
    line_phase = 4'd9; check("R3");

    // R5: mode switch same cycle
    pix = {3{2'b01}}; ps_mode = 1'b1; line_phase = 4'd3; check("R5");
    ps_mode = 1'b0; check("R5");

    // R7: width 15 still off at phase 15
    set_word(0, 16'hFFFF);
    pix = '0; line_phase = 4'd14; check("R7");
    line_phase = 4'd15; check("R7");

    // R6: display off overrides
    disp_on = 1'b0; line_phase = 4'd0; check("R6");
    disp_on = 1'b1; check("R6");

    // R8: slots with different codes
    pix = {2'b00, 2'b11, 2'b10};
    line_phase = 4'd2; check("R8");

    // Random mix
    for (int i = 0; i < 8; i++) set_word(i, 16'($urandom));
    for (int n = 0; n < 600; n++) begin
      int c;
      c = $urandom_range(0, 9);
      if (c == 0) tick();
      else if (c == 1) wr(4'($urandom), 8'($urandom));
      else begin
        @(negedge clk);
        pix = 6'($urandom);
        ps_mode = 1'($urandom);
        disp_on = ($urandom_range(0, 7) != 0);
        line_phase = 4'($urandom);
        check("R4/R5/R8 random");
      end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule